// File: doc/BRIEF.md
# Register-Cached Data Stack

This block is the operand stack of a small stack-oriented processor. The two topmost items are kept in flip-flops, so the ALU can read them at once without going through memory. Every deeper item lives in a two-port RAM. A depth register tracks how many items are held. The RAM cell of the third item sits at depth minus three, and the fourth item sits one cell below that. The stack grows upward one whole cell at a time.

Each cycle a decoded 4-bit stack operation arrives on `op`. The operation picks the next top item, the next second item and a depth adjustment of -2, -1, 0 or +1. The new top item can come from a shared result path that carries the ALU output, a literal, memory read data, the top of the return stack, or the current second item. It can also come from the third cell. The RAM is written only when a register value is displaced into the third slot. The write address is formed from the already-adjusted depth in the same cycle. Both read ports are combinational, so a cell read in one cycle is registered into a stack register at the next edge. The second read port is enabled only for the two-item pop.

An operation that needs more items than the stack holds is refused, and it raises a sticky underflow flag. A growing operation on a full stack is also refused, and it raises a sticky overflow flag. A refused operation changes neither the registers nor the depth.

Top module: `dstack`

## Requirements
- R1: After reset, `depth` is 0, `tos` and `nos` are 0, and both `underflow` and `overflow` are 0.
- R2: The push codes are 1 (literal from `lit_val`), 2 (memory data from `mem_rdata`), 3 (return-stack top from `rstk_top`), 4 (copy top) and 5 (copy second). Each push places its value on top, moves the old top to second and the old second to third, and raises depth by one. Copy top needs 1 item and copy second needs 2 items.
- R3: Code 6 drops the top item and needs 1 item. Code 7 removes the second item and keeps the top, and it needs 2 items. Code 13 replaces the top two items with `alu_res` and needs 2 items. Each of these lowers depth by one, and the old third item becomes second.
- R4: Code 12 replaces the top item with `alu_res` and keeps depth and the second item. It needs 1 item.
- R5: Code 14 removes two items. The old third and fourth items become top and second, and depth falls by two. It needs 2 items.
- R6: Code 8 exchanges the top two items and keeps depth. It needs 2 items.
- R7: Code 9 turns (a b) into (b a b), where b is the top, and raises depth by one. It needs 2 items.
- R8: Code 10 turns (a b c) into (b c a), where c is the top. Code 11 turns (a b c) into (c a b). Both keep depth and need 3 items.
- R9: An operation on a stack that holds fewer items than the operation needs sets `underflow`. The flag stays set until reset, and the stack is left unchanged.
- R10: A growing operation (codes 1 to 5 and 9) on a stack that holds DEPTH items sets `overflow`. The flag stays set until reset, and the stack is left unchanged. The depth never exceeds DEPTH.
- R11: Items pushed until the stack is full come back in reverse order when they are dropped one by one.
- R12: Codes 0 and 15 leave the stack, depth and flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 4 | Decoded stack operation code |
| alu_res | input | DATA_W | ALU result for the current operands |
| lit_val | input | DATA_W | Literal value for a literal push |
| mem_rdata | input | DATA_W | Memory read data for a fetch push |
| rstk_top | input | DATA_W | Top of the return stack |
| tos | output | DATA_W | Top stack item |
| nos | output | DATA_W | Second stack item |
| depth | output | clog2(DEPTH+1) | Number of items on the stack |
| underflow | output | 1 | Sticky underflow flag |
| overflow | output | 1 | Sticky overflow flag |

## Verification
Several rules are checked by assertions on every cycle:
- the depth bound;
- the stickiness of both error flags;
- a refused operation leaves the depth frozen;
- a RAM write only happens when the depth does not fall;
- a paired read never coincides with a write.

The data motions need the bench's scenarios: the values that end up in the top and second registers, and the contents of the deep cells after rotations, tucks and double pops. The bench compares each operation against its own model of the stack. This covers a fill to full depth, a drain back to empty, and a long pseudo-random operation stream.

// File: rtl/dstk_pkg.sv
package dstk_pkg;

  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_LIT   = 4'd1,
    OP_FETCH = 4'd2,
    OP_FROMR = 4'd3,
    OP_DUP   = 4'd4,
    OP_OVER  = 4'd5,
    OP_DROP  = 4'd6,
    OP_NIP   = 4'd7,
    OP_SWAP  = 4'd8,
    OP_TUCK  = 4'd9,
    OP_ROT   = 4'd10,
    OP_NROT  = 4'd11,
    OP_ALU1  = 4'd12,
    OP_ALU2  = 4'd13,
    OP_DROP2 = 4'd14,
    OP_RSVD  = 4'd15
  } op_e;

  // result path feeding the top register
  typedef enum logic [2:0] {
    RES_ALU, RES_LIT, RES_MEM, RES_RSTK, RES_NOS
  } res_e;

  typedef enum logic [1:0] {T_HOLD, T_RES, T_THIRD} tsel_e;
  typedef enum logic [1:0] {N_HOLD, N_TOS, N_THIRD, N_FOURTH} nsel_e;

  typedef struct packed {
    res_e             res;
    tsel_e            tsel;
    nsel_e            nsel;
    logic signed [2:0] adj;
    logic             wr;      // write a displaced value into the third slot
    logic             wr_tos;  // displaced value is the top (else the second)
    logic             rd2;     // second read port needed
  } ctrl_t;

  // items an operation must find on the stack
  function automatic int need_of(op_e op);
    case (op)
      OP_DUP, OP_DROP, OP_ALU1:                           return 1;
      OP_OVER, OP_NIP, OP_SWAP, OP_TUCK, OP_ALU2, OP_DROP2: return 2;
      OP_ROT, OP_NROT:                                     return 3;
      default:                                             return 0;
    endcase
  endfunction

  function automatic ctrl_t decode_op(op_e op);
    ctrl_t c;
    c = '{res: RES_ALU, tsel: T_HOLD, nsel: N_HOLD, adj: 3'sd0,
          wr: 1'b0, wr_tos: 1'b0, rd2: 1'b0};
    case (op)
      OP_LIT, OP_FETCH, OP_FROMR, OP_OVER: begin
        c.res  = (op == OP_LIT)   ? RES_LIT :
                 (op == OP_FETCH) ? RES_MEM :
                 (op == OP_FROMR) ? RES_RSTK : RES_NOS;
        c.tsel = T_RES;
        c.nsel = N_TOS;
        c.adj  = 3'sd1;
        c.wr   = 1'b1;
      end
      OP_DUP: begin
        c.nsel = N_TOS;
        c.adj  = 3'sd1;
        c.wr   = 1'b1;
      end
      OP_DROP: begin
        c.res  = RES_NOS;
        c.tsel = T_RES;
        c.nsel = N_THIRD;
        c.adj  = -3'sd1;
      end
      OP_NIP: begin
        c.nsel = N_THIRD;
        c.adj  = -3'sd1;
      end
      OP_SWAP: begin
        c.res  = RES_NOS;
        c.tsel = T_RES;
        c.nsel = N_TOS;
      end
      OP_TUCK: begin
        c.adj    = 3'sd1;
        c.wr     = 1'b1;
        c.wr_tos = 1'b1;
      end
      OP_ROT: begin
        c.tsel = T_THIRD;
        c.nsel = N_TOS;
        c.wr   = 1'b1;
      end
      OP_NROT: begin
        c.res    = RES_NOS;
        c.tsel   = T_RES;
        c.nsel   = N_THIRD;
        c.wr     = 1'b1;
        c.wr_tos = 1'b1;
      end
      OP_ALU1: c.tsel = T_RES;
      OP_ALU2: begin
        c.tsel = T_RES;
        c.nsel = N_THIRD;
        c.adj  = -3'sd1;
      end
      OP_DROP2: begin
        c.tsel = T_THIRD;
        c.nsel = N_FOURTH;
        c.adj  = -3'sd2;
        c.rd2  = 1'b1;
      end
      default: ;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/dstk_ctl.sv
module dstk_ctl
  import dstk_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PW    = 5
) (
  input  logic [3:0]    op,
  input  logic [PW-1:0] depth,
  output ctrl_t         ctrl,
  output logic          uf_ev,
  output logic          of_ev
);

  ctrl_t raw;

  always_comb begin
    raw   = decode_op(op_e'(op));
    uf_ev = int'(depth) < need_of(op_e'(op));
    of_ev = !uf_ev && (raw.adj == 3'sd1) && (int'(depth) == DEPTH);
    // a refused operation becomes a no-op
    ctrl  = (uf_ev || of_ev) ? decode_op(OP_NOP) : raw;
  end

endmodule

// File: rtl/dstk_ptr.sv
module dstk_ptr #(
  parameter int DEPTH = 16,
  parameter int PW    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic signed [2:0] adj,
  input  logic              uf_ev,
  input  logic              of_ev,
  output logic [PW-1:0]     ptr,
  output logic [PW-1:0]     ptr_nxt,
  output logic              underflow,
  output logic              overflow
);

  // the adjusted value is visible during the cycle for RAM addressing
  assign ptr_nxt = ptr + PW'(adj);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr       <= '0;
      underflow <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      ptr <= ptr_nxt;
      if (uf_ev) underflow <= 1'b1;
      if (of_ev) overflow  <= 1'b1;
    end
  end

  assert_depth_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= PW'(DEPTH));
  assert_uflow_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);
  assert_oflow_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  assert_uflow_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    uf_ev |=> underflow);
  assert_oflow_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    of_ev |=> overflow);
  assert_refuse_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_ev || of_ev) |=> $stable(ptr));

endmodule

// File: rtl/dstk_ram.sv
module dstk_ram #(
  parameter int W  = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic          rd_b_en,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);

  localparam int CELLS = 1 << AW;

  logic [W-1:0] mem [CELLS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = rd_b_en ? mem[raddr_b] : '0;

  // a paired read (two-item pop) never displaces anything into RAM
  assert_pair_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_b_en |-> !we);

endmodule

// File: rtl/dstk_regs.sv
module dstk_regs
  import dstk_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  tsel_e        tsel,
  input  nsel_e        nsel,
  input  logic [W-1:0] res,
  input  logic [W-1:0] third,
  input  logic [W-1:0] fourth,
  output logic [W-1:0] tos,
  output logic [W-1:0] nos
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tos <= '0;
      nos <= '0;
    end else begin
      case (tsel)
        T_RES:   tos <= res;
        T_THIRD: tos <= third;
        default: tos <= tos;
      endcase
      case (nsel)
        N_TOS:    nos <= tos;
        N_THIRD:  nos <= third;
        N_FOURTH: nos <= fourth;
        default:  nos <= nos;
      endcase
    end
  end

endmodule

// File: rtl/dstack.sv
module dstack
  import dstk_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [3:0]                 op,
  input  logic [DATA_W-1:0]          alu_res,
  input  logic [DATA_W-1:0]          lit_val,
  input  logic [DATA_W-1:0]          mem_rdata,
  input  logic [DATA_W-1:0]          rstk_top,
  output logic [DATA_W-1:0]          tos,
  output logic [DATA_W-1:0]          nos,
  output logic [$clog2(DEPTH+1)-1:0] depth,
  output logic                       underflow,
  output logic                       overflow
);

  localparam int PW = $clog2(DEPTH + 1);
  localparam int AW = $clog2(DEPTH);

  ctrl_t             ctrl;
  logic              uf_ev, of_ev;
  logic [PW-1:0]     ptr, ptr_nxt;
  logic [AW-1:0]     a_third, a_fourth, a_wr;
  logic              we;
  logic [DATA_W-1:0] third, fourth, wdata, res;

  dstk_ctl #(.DEPTH(DEPTH), .PW(PW)) u_ctl (
    .op(op), .depth(ptr), .ctrl(ctrl), .uf_ev(uf_ev), .of_ev(of_ev)
  );

  dstk_ptr #(.DEPTH(DEPTH), .PW(PW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .adj(ctrl.adj), .uf_ev(uf_ev), .of_ev(of_ev),
    .ptr(ptr), .ptr_nxt(ptr_nxt), .underflow(underflow), .overflow(overflow)
  );

  // third item sits at depth-3, fourth at depth-4; writes target the new third slot
  assign a_third  = AW'(ptr - PW'(3));
  assign a_fourth = AW'(ptr - PW'(4));
  assign a_wr     = AW'(ptr_nxt - PW'(3));
  assign we       = ctrl.wr && (ptr_nxt >= PW'(3));
  assign wdata    = ctrl.wr_tos ? tos : nos;

  dstk_ram #(.W(DATA_W), .AW(AW)) u_ram (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(a_wr), .wdata(wdata),
    .raddr_a(a_third), .rd_b_en(ctrl.rd2), .raddr_b(a_fourth),
    .rdata_a(third), .rdata_b(fourth)
  );

  always_comb begin
    case (ctrl.res)
      RES_LIT:  res = lit_val;
      RES_MEM:  res = mem_rdata;
      RES_RSTK: res = rstk_top;
      RES_NOS:  res = nos;
      default:  res = alu_res;
    endcase
  end

  dstk_regs #(.W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .tsel(ctrl.tsel), .nsel(ctrl.nsel),
    .res(res), .third(third), .fourth(fourth), .tos(tos), .nos(nos)
  );

  assign depth = ptr;

  // RAM is only written by operations that do not shrink the stack
  assert_write_grow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (ptr_nxt >= ptr));

endmodule

// File: tb/tb_dstack.sv
`timescale 1ns/1ps
module tb_dstack;

  localparam int W     = 32;
  localparam int DEPTH = 16;
  localparam int PW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    op = 4'd0;
  logic [W-1:0]  alu_res = '0, lit_val = '0, mem_rdata = '0, rstk_top = '0;
  logic [W-1:0]  tos, nos;
  logic [PW-1:0] depth;
  logic          underflow, overflow;

  always #4 clk = ~clk;

  dstack #(.DATA_W(W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .op(op), .alu_res(alu_res), .lit_val(lit_val),
    .mem_rdata(mem_rdata), .rstk_top(rstk_top), .tos(tos), .nos(nos),
    .depth(depth), .underflow(underflow), .overflow(overflow)
  );

  int  checks = 0;
  int  errors = 0;
  bit  done = 0;

  // reference model and scoreboard
  logic [W-1:0] m [$];
  bit           mu = 0, mo = 0;
  logic [W-1:0] q_t [$];
  logic [W-1:0] q_n [$];
  int           q_d [$];
  bit           q_uf [$];
  bit           q_of [$];
  string        q_tag [$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int need(input logic [3:0] o);
    case (o)
      4'd4, 4'd6, 4'd12:                      return 1;
      4'd5, 4'd7, 4'd8, 4'd9, 4'd13, 4'd14:   return 2;
      4'd10, 4'd11:                           return 3;
      default:                                return 0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'd1, 4'd2, 4'd3, 4'd4, 4'd5: return "R2";
      4'd6, 4'd7, 4'd13:            return "R3";
      4'd12:                        return "R4";
      4'd14:                        return "R5";
      4'd8:                         return "R6";
      4'd9:                         return "R7";
      4'd10, 4'd11:                 return "R8";
      default:                      return "R12";
    endcase
  endfunction

  // monitor: compare every queued expectation away from the active edge
  always @(negedge clk) begin
    while (q_d.size() > 0) begin
      automatic logic [W-1:0] et = q_t.pop_front();
      automatic logic [W-1:0] en = q_n.pop_front();
      automatic int           ed = q_d.pop_front();
      automatic bit           eu = q_uf.pop_front();
      automatic bit           eo = q_of.pop_front();
      automatic string        tg = q_tag.pop_front();
      chk(int'(depth) == ed, tg, "depth", longint'(depth), longint'(ed));
      chk(underflow == eu, tg, "underflow", longint'(underflow), longint'(eu));
      chk(overflow == eo, tg, "overflow", longint'(overflow), longint'(eo));
      if (ed >= 1) chk(tos == et, tg, "tos", longint'(tos), longint'(et));
      if (ed >= 2) chk(nos == en, tg, "nos", longint'(nos), longint'(en));
    end
  end

  task automatic step(input logic [3:0] o, input logic [W-1:0] a,
                      input logic [W-1:0] l, input logic [W-1:0] mv,
                      input logic [W-1:0] rv, input string tov);
    int d;
    string tg;
    logic [W-1:0] x, y, z;
    @(negedge clk);
    op = o; alu_res = a; lit_val = l; mem_rdata = mv; rstk_top = rv;
    d  = m.size();
    tg = (tov != "") ? tov : tag_of(o);
    if (d < need(o)) begin
      mu = 1; tg = "R9";
    end else if ((o inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd9}) && d == DEPTH) begin
      mo = 1; tg = "R10";
    end else begin
      case (o)
        4'd1:  m.push_back(l);
        4'd2:  m.push_back(mv);
        4'd3:  m.push_back(rv);
        4'd4:  m.push_back(m[d-1]);
        4'd5:  m.push_back(m[d-2]);
        4'd6:  void'(m.pop_back());
        4'd7:  begin x = m.pop_back(); void'(m.pop_back()); m.push_back(x); end
        4'd8:  begin x = m[d-1]; m[d-1] = m[d-2]; m[d-2] = x; end
        4'd9:  begin x = m[d-1]; y = m[d-2]; m[d-2] = x; m[d-1] = y; m.push_back(x); end
        4'd10: begin x = m[d-3]; y = m[d-2]; z = m[d-1];
                     m[d-3] = y; m[d-2] = z; m[d-1] = x; end
        4'd11: begin x = m[d-3]; y = m[d-2]; z = m[d-1];
                     m[d-3] = z; m[d-2] = x; m[d-1] = y; end
        4'd12: m[d-1] = a;
        4'd13: begin void'(m.pop_back()); void'(m.pop_back()); m.push_back(a); end
        4'd14: begin void'(m.pop_back()); void'(m.pop_back()); end
        default: ;
      endcase
    end
    @(posedge clk);
    #1;
    d = m.size();
    q_t.push_back(d >= 1 ? m[d-1] : '0);
    q_n.push_back(d >= 2 ? m[d-2] : '0);
    q_d.push_back(d);
    q_uf.push_back(mu);
    q_of.push_back(mo);
    q_tag.push_back(tg);
  endtask

  task automatic op1(input logic [3:0] o, input logic [W-1:0] v);
    step(o, v ^ 32'h5A5A_0000, v, v + 32'h100, v + 32'h200, "");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; op = 4'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    m.delete(); mu = 0; mo = 0;
    #1;
    // R1: reset state
    chk(depth == '0, "R1", "depth", longint'(depth), 0);
    chk(tos == '0, "R1", "tos", longint'(tos), 0);
    chk(nos == '0, "R1", "nos", longint'(nos), 0);
    chk(underflow == 1'b0, "R1", "underflow", longint'(underflow), 0);
    chk(overflow == 1'b0, "R1", "overflow", longint'(overflow), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    // directed motions
    op1(4'd1, 32'h11);          // R2 literal
    op1(4'd2, 32'h22);          // R2 fetch
    op1(4'd3, 32'h33);          // R2 from return stack
    op1(4'd4, 32'h0);           // R2 dup
    op1(4'd5, 32'h0);           // R2 over
    op1(4'd8, 32'h0);           // R6 swap
    op1(4'd9, 32'h0);           // R7 tuck
    op1(4'd10, 32'h0);          // R8 rot
    op1(4'd11, 32'h0);          // R8 -rot
    op1(4'd12, 32'h77);         // R4 unary alu
    op1(4'd13, 32'h88);         // R3 binary alu
    op1(4'd7, 32'h0);           // R3 nip
    op1(4'd0, 32'h0);           // R12
    op1(4'd15, 32'h0);          // R12
    op1(4'd14, 32'h0);          // R5 double pop
    op1(4'd6, 32'h0);           // R3 drop
    for (int i = 0; i < 3; i++) op1(4'd10, 32'h0);
    for (int i = 0; i < 4; i++) op1(4'd14, 32'h0);

    // R11 fill to full, R10 overflow, R11 drain, R9 underflow
    do_reset();
    for (int i = 0; i < DEPTH; i++)
      step(4'd1, '0, 32'hC000 + i, '0, '0, "R11");
    op1(4'd4, 32'h0);           // R10 refused push
    op1(4'd9, 32'h0);           // R10 refused tuck
    for (int i = 0; i < DEPTH; i++)
      step(4'd6, '0, '0, '0, '0, "R11");
    op1(4'd6, 32'h0);           // R9 drop on empty
    op1(4'd1, 32'h99);          // R2 push after underflow, flag stays
    op1(4'd10, 32'h0);          // R9 rot with one item

    // pseudo-random stream
    do_reset();
    for (int i = 0; i < 1500; i++) begin
      automatic logic [3:0] o = 4'($urandom_range(0, 15));
      if (m.size() < 4 && $urandom_range(0, 2) != 0) o = 4'd1;
      if (m.size() > 12 && $urandom_range(0, 2) != 0) o = 4'd14;
      step(o, $urandom(), $urandom(), $urandom(), $urandom(), "");
    end

    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule